// File: doc/BRIEF.md
# Separate-I/O Quad Data Rate Static Memory

This block is a synthesizable model of a static memory with separate write and read data buses, each running at double data rate, and one shared address bus. Every input clock period has two halves. The block runs on one internal clock at twice the input clock rate. After reset it tracks which half is current with a phase bit of its own. The first internal cycle after reset release is the rising half. After that the halves alternate. The output clock is taken as aligned with the input clock, so the read data halves match the input halves.

A write is started by pulling the write strobe low in a rising half. The block then takes one data word in that half and a second data word in the following complement half, together with the write address. A read is started by pulling the read strobe low in a rising half, with the read address. The block returns two words, at A and at A+1, over the next period. A read and a write can be issued in the same period, so a host can keep both buses busy all the time.

The storage sits in two banks of one port each, one for even word addresses and one for odd word addresses, so that one access covers a whole burst of two. The rising half is the write slot and the complement half is the read slot. A write is committed one half-cycle after its last word arrives. A read in the same period as a write sees the new data through a bypass path.

Top module: `qdr_sram`

## Requirements
- R1: While rst_ni is low and after its release, until a read is issued, rvalid_o is 0 and rdata_o is 0.
- R2: The first clk_i cycle after reset release is a rising half, and the halves alternate after that. The block samples wps_ni and rps_ni only in rising halves. Strobes held low in a complement half start no read and write nothing.
- R3: When wps_ni is low in a rising half, the wdata_i word of that half is stored at address W and the wdata_i word of the next complement half is stored at W+1. W is the addr_i value of that complement half. W may be even or odd.
- R4: When rps_ni is low in a rising half with addr_i = A, the word at A is on rdata_o during the second clk_i cycle after that sampling edge. The word at A+1 follows in the cycle after it. rvalid_o is 1 in exactly those two cycles.
- R5: The second address of a burst is the first address plus one, modulo 2^AW. So a burst at 2^AW-1 uses address 0 for its second word, for both writes and reads.
- R6: A read and a write may be issued in every period, back to back. Each read returns both words, and rvalid_o then stays high with no gap.
- R7: A read issued in the same period as a write returns the new data for every read word whose address equals W or W+1 of that write.
- R8: In a cycle where rvalid_o is 0, rdata_o keeps the last word that was driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock at twice the input clock rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Read address in rising halves, write address in complement halves |
| wps_ni | input | 1 | Write strobe, active low, sampled in rising halves |
| rps_ni | input | 1 | Read strobe, active low, sampled in rising halves |
| wdata_i | input | DW | Write data, one word in each half |
| rdata_o | output | DW | Read data, one word in each half |
| rvalid_o | output | 1 | High in each cycle where rdata_o carries a read word |

## Verification
The bench targets these corner cases:
- **Odd and top addresses.** A burst at an odd address touches two different rows of the two banks. A mapping error would store or return the neighbouring word.
- **Bursts at the top address.** These must wrap to 0. A design that carries into a missing address bit would write row 0 of the wrong bank or return stale data.
- **Same-period overlap.** Reads overlapping the same period's write are tried with full overlap and with overlap of either single word, including overlap across the wrap. A design without the bypass returns the old contents.
- **Complement-half strobes.** These are checked for having no effect by reading the target address back.
- **Back-to-back traffic and idle periods.** Back-to-back traffic exposes a lost or shifted half-cycle. Idle periods expose a read bus that does not hold its last word.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  typedef enum logic {
    HALF_RISE = 1'b0,
    HALF_FALL = 1'b1
  } half_e;
endpackage

// File: rtl/qdr_bank.sv
module qdr_bank #(
  parameter int ROW_W = 5,
  parameter int DW    = 16
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  localparam int ROWS = 1 << ROW_W;

  logic [DW-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[row_i] <= wdata_i;
  end

  assign rdata_o = mem_q[row_i];
endmodule

// File: rtl/qdr_pair_map.sv
// Splits a two-word burst at base_i into one row per bank (index 0 even, 1 odd).
module qdr_pair_map #(
  parameter int AW = 6
) (
  input  logic [AW-1:0]         base_i,
  output logic [1:0][AW-2:0]    row_o
);
  logic [AW-1:0] next_w;

  assign next_w = base_i + 1'b1;

  always_comb begin
    if (base_i[0]) begin
      row_o[1] = base_i[AW-1:1];
      row_o[0] = next_w[AW-1:1];
    end else begin
      row_o[0] = base_i[AW-1:1];
      row_o[1] = next_w[AW-1:1];
    end
  end
endmodule

// File: rtl/qdr_fwd.sv
// Replaces core read words with data of a same-period write not yet committed.
module qdr_fwd #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic [AW-1:0] rd_addr_i,
  input  logic [DW-1:0] core0_i,
  input  logic [DW-1:0] core1_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_d0_i,
  input  logic [DW-1:0] wr_d1_i,
  output logic [DW-1:0] q0_o,
  output logic [DW-1:0] q1_o
);
  logic [AW-1:0] rd_nxt, wr_nxt;
  logic [1:0][AW-1:0] rd_w;
  logic [1:0][DW-1:0] core_w, q_w;

  assign rd_nxt = rd_addr_i + 1'b1;
  assign wr_nxt = wr_addr_i + 1'b1;
  assign rd_w   = {rd_nxt, rd_addr_i};
  assign core_w = {core1_i, core0_i};

  for (genvar g = 0; g < 2; g++) begin : g_word
    always_comb begin
      q_w[g] = core_w[g];
      if (wr_en_i && rd_w[g] == wr_addr_i)   q_w[g] = wr_d0_i;
      else if (wr_en_i && rd_w[g] == wr_nxt) q_w[g] = wr_d1_i;
    end
  end

  assign q0_o = q_w[0];
  assign q1_o = q_w[1];
endmodule

// File: rtl/qdr_sram.sv
module qdr_sram
  import qdr_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wps_ni,
  input  logic          rps_ni,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  localparam int ROW_W = AW - 1;

  half_e         half_q;
  logic          rd_pend_q, wr_pend_q, wc_en_q, r2_q;
  logic [AW-1:0] ra_q, wc_addr_q;
  logic [DW-1:0] wd0_q, wc_d0_q, wc_d1_q, rhold_q;

  logic [1:0][ROW_W-1:0] rd_row, wr_row;
  logic [1:0][DW-1:0]    bank_wd, bank_rd;
  logic [DW-1:0]         core0, core1, fq0, fq1;
  logic                  wr_slot;

  assign wr_slot = (half_q == HALF_RISE);

  qdr_pair_map #(.AW(AW)) i_rd_map (.base_i(ra_q),      .row_o(rd_row));
  qdr_pair_map #(.AW(AW)) i_wr_map (.base_i(wc_addr_q), .row_o(wr_row));

  assign bank_wd[0] = wc_addr_q[0] ? wc_d1_q : wc_d0_q;
  assign bank_wd[1] = wc_addr_q[0] ? wc_d0_q : wc_d1_q;

  // Single port per bank: rising half writes, complement half reads.
  for (genvar b = 0; b < 2; b++) begin : g_bank
    qdr_bank #(.ROW_W(ROW_W), .DW(DW)) i_bank (
      .clk_i   (clk_i),
      .we_i    (wr_slot && wc_en_q),
      .row_i   (wr_slot ? wr_row[b] : rd_row[b]),
      .wdata_i (bank_wd[b]),
      .rdata_o (bank_rd[b])
    );
  end

  assign core0 = ra_q[0] ? bank_rd[1] : bank_rd[0];
  assign core1 = ra_q[0] ? bank_rd[0] : bank_rd[1];

  qdr_fwd #(.AW(AW), .DW(DW)) i_fwd (
    .rd_addr_i (ra_q),
    .core0_i   (core0),
    .core1_i   (core1),
    .wr_en_i   (wr_pend_q),
    .wr_addr_i (addr_i),
    .wr_d0_i   (wd0_q),
    .wr_d1_i   (wdata_i),
    .q0_o      (fq0),
    .q1_o      (fq1)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q    <= HALF_RISE;
      rd_pend_q <= 1'b0;
      wr_pend_q <= 1'b0;
      wc_en_q   <= 1'b0;
      r2_q      <= 1'b0;
      ra_q      <= '0;
      wc_addr_q <= '0;
      wd0_q     <= '0;
      wc_d0_q   <= '0;
      wc_d1_q   <= '0;
      rhold_q   <= '0;
      rdata_o   <= '0;
      rvalid_o  <= 1'b0;
    end else begin
      half_q <= (half_q == HALF_RISE) ? HALF_FALL : HALF_RISE;
      if (half_q == HALF_RISE) begin
        rd_pend_q <= ~rps_ni;
        wr_pend_q <= ~wps_ni;
        ra_q      <= addr_i;
        wd0_q     <= wdata_i;
        rvalid_o  <= r2_q;
        r2_q      <= 1'b0;
        if (r2_q) rdata_o <= rhold_q;
      end else begin
        wc_en_q   <= wr_pend_q;
        wc_addr_q <= addr_i;
        wc_d0_q   <= wd0_q;
        wc_d1_q   <= wdata_i;
        rvalid_o  <= rd_pend_q;
        r2_q      <= rd_pend_q;
        if (rd_pend_q) begin
          rdata_o <= fq0;
          rhold_q <= fq1;
        end
      end
    end
  end
endmodule

// File: rtl/qdr_sram_chk.sv
module qdr_sram_chk #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rps_ni,
  input logic [DW-1:0] rdata_o,
  input logic          rvalid_o
);
  logic half_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) half_c <= 1'b0;
    else         half_c <= ~half_c;
  end

  p_rise_aligned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rvalid_o) |-> !half_c);

  p_read_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!half_c && !rps_ni) |=> ##1 rvalid_o);

  p_read_second_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!half_c && !rps_ni) |=> ##2 rvalid_o);

  p_no_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!half_c && rps_ni) |=> ##1 !rvalid_o ##1 !rvalid_o);

  p_hold_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> rvalid_o);
endmodule

bind qdr_sram qdr_sram_chk #(.DW(DW)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rps_ni   (rps_ni),
  .rdata_o  (rdata_o),
  .rvalid_o (rvalid_o)
);

// File: tb/test_qdr_sram.sv
module test_qdr_sram;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          wps_ni = 1'b1;
  logic          rps_ni = 1'b1;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          rvalid_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  logic [DW-1:0] ref_mem [WORDS];
  logic [DW-1:0] exp_d [$];
  int            exp_t [$];
  string         exp_r [$];
  logic [DW-1:0] last_rd = '0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  qdr_sram #(.AW(AW), .DW(DW)) i_qdr_sram (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wps_ni(wps_ni),
    .rps_ni(rps_ni), .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  task automatic check(input bit ok, input string req, input logic [DW:0] act,
                       input logic [DW:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Output monitor: every expected word at its cycle, no valid otherwise.
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (exp_t.size() > 0 && exp_t[0] == cyc) begin
        check(rvalid_o && rdata_o == exp_d[0], exp_r[0],
              {rvalid_o, rdata_o}, {1'b1, exp_d[0]});
        void'(exp_d.pop_front());
        void'(exp_t.pop_front());
        void'(exp_r.pop_front());
      end else if (rvalid_o) begin
        check(1'b0, "R4", {rvalid_o, rdata_o}, '0);
      end
    end
  end

  // One input period, entered and left at a falling clk edge.
  task automatic k_cycle(input bit rd, input logic [AW-1:0] ra,
                         input bit wr, input logic [AW-1:0] wa,
                         input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                         input string tag, input bit fall_noise = 1'b0);
    logic [AW-1:0] wa1, ra1;
    int p;
    wa1 = wa + 1'b1;
    ra1 = ra + 1'b1;
    rps_ni = !rd; wps_ni = !wr; addr_i = ra; wdata_i = d0;
    p = cyc + 1;
    if (wr) begin ref_mem[wa] = d0; ref_mem[wa1] = d1; end
    if (rd) begin
      exp_d.push_back(ref_mem[ra]);  exp_t.push_back(p + 1); exp_r.push_back(tag);
      exp_d.push_back(ref_mem[ra1]); exp_t.push_back(p + 2); exp_r.push_back(tag);
      last_rd = ref_mem[ra1];
    end
    @(negedge clk);
    rps_ni = !fall_noise; wps_ni = !fall_noise; addr_i = wa; wdata_i = d1;
    @(negedge clk);
    rps_ni = 1'b1; wps_ni = 1'b1;
  endtask

  task automatic flush(input string tag);
    k_cycle(0, '0, 0, '0, '0, '0, tag);
    k_cycle(0, '0, 0, '0, '0, '0, tag);
    check(exp_t.size() == 0, tag, exp_t.size(), 0);
  endtask

  task automatic t_reset;
    check(rvalid_o == 1'b0 && rdata_o == '0, "R1", {rvalid_o, rdata_o}, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); @(negedge clk);
    check(rvalid_o == 1'b0 && rdata_o == '0, "R1", {rvalid_o, rdata_o}, '0);
  endtask

  task automatic t_fill;
    for (int a = 0; a < WORDS; a += 2)
      k_cycle(0, '0, 1, AW'(a), DW'(a * 37 + 5), DW'((a + 1) * 37 + 5), "R3");
    for (int a = 0; a < WORDS; a += 2)
      k_cycle(1, AW'(a), 0, '0, '0, '0, "R3");
    flush("R4");
  endtask

  task automatic t_odd;
    k_cycle(0, '0, 1, 6'd5, 16'hA505, 16'hA606, "R3");
    k_cycle(1, 6'd4, 0, '0, '0, '0, "R3");
    k_cycle(1, 6'd5, 0, '0, '0, '0, "R3");
    flush("R3");
  endtask

  task automatic t_wrap;
    k_cycle(0, '0, 1, 6'd63, 16'hE63E, 16'hE00E, "R5");
    k_cycle(1, 6'd63, 0, '0, '0, '0, "R5");
    k_cycle(1, 6'd0, 0, '0, '0, '0, "R5");
    k_cycle(1, 6'd62, 0, '0, '0, '0, "R5");
    flush("R5");
  endtask

  task automatic t_interleave;
    for (int i = 0; i < 8; i++)
      k_cycle(1, AW'(i * 7 + 1), 1, AW'(i * 5 + 32), DW'(16'hC000 + i),
              DW'(16'hD000 + i), "R6");
    flush("R6");
  endtask

  task automatic t_forward;
    k_cycle(1, 6'd10, 1, 6'd10, 16'hF010, 16'hF011, "R7");
    k_cycle(1, 6'd20, 1, 6'd21, 16'hF021, 16'hF022, "R7");
    k_cycle(1, 6'd31, 1, 6'd30, 16'hF030, 16'hF031, "R7");
    k_cycle(1, 6'd0,  1, 6'd63, 16'hF063, 16'hF000, "R7");
    flush("R7");
  endtask

  task automatic t_fall_ignored;
    k_cycle(0, 6'd40, 0, 6'd40, 16'hBAD0, 16'hBAD1, "R2", 1'b1);
    flush("R2");
    k_cycle(1, 6'd40, 0, '0, '0, '0, "R2");
    flush("R2");
  endtask

  task automatic t_idle;
    k_cycle(1, 6'd12, 0, '0, '0, '0, "R8");
    flush("R8");
    k_cycle(0, '0, 0, '0, '0, '0, "R8");
    check(rvalid_o == 1'b0 && rdata_o == last_rd, "R8",
          {rvalid_o, rdata_o}, {1'b0, last_rd});
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_fill();
    t_odd();
    t_wrap();
    t_interleave();
    t_forward();
    t_fall_ignored();
    t_idle();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule